// File: doc/BRIEF.md
# Nine-bit UART receiver with address filter

This block takes an asynchronous serial line and recovers eleven-bit frames. Each frame is a low start bit, eight data bits sent least significant first, a ninth bit, and a stop bit. Bit timing comes from a tick input that pulses sixteen times per bit period. When a frame ends, an acceptance rule decides whether the received byte, its ninth bit and a receive-complete flag are updated. Otherwise the frame is dropped and the host-visible state keeps its previous values.

The acceptance rule serves multi-drop links. A ninth bit of 1 marks an address frame and a ninth bit of 0 marks a data frame. A slave that sets the multiprocessor-enable input only sees address frames, so the host wakes on addresses alone. The host clears that input once it has matched its own address, and then it sees the data frames that follow. The block also never overwrites a byte the host has not yet acknowledged with the flag-clear strobe.

Top module: `uart9_addr_rx`

## Requirements
- R1: Start bits are detected only while rx_en is 1. Driving rx_en to 0 abandons any frame in progress, so no load happens for it. After rx_en returns to 1 and the line is idle high, the next frame is received normally.
- R2: After an accepted frame, rx_data holds the eight data bits, with the first data bit after the start bit in rx_data[0]. rx_bit9 holds the ninth bit. The stop bit's level (0 or 1) has no effect on acceptance.
- R3: While rx_full is 1, a completed frame is rejected and rx_data and rx_bit9 keep their values.
- R4: With mp_en = 1, a frame whose ninth bit is 0 is rejected and leaves rx_data, rx_bit9 and rx_full unchanged. A frame whose ninth bit is 1 is accepted when rx_full is 0.
- R5: With mp_en = 0, frames are accepted whatever their ninth bit is, when rx_full is 0.
- R6: A start is seen when, at a tick, the synchronised line is low after being high at the previous tick. It is confirmed only if the line is still low 8 ticks later. If the line is high at that point, the receiver returns to idle without loading anything.
- R7: Each of the nine following bits is sampled once, 16 ticks after the previous sample point. The frame completes 16 ticks after the ninth-bit sample. rx_in passes through 2 register stages before sampling, and the outputs change at the clock edge where the completing tick is sampled.
- R8: Acceptance sets rx_full to 1. rx_full then stays 1 until a flag_clr pulse, which makes it 0 at the next edge. Acceptance is judged on the flag value before any flag_clr in the same cycle.
- R9: After reset, rx_full, rx_bit9 and rx_data are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_in | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | One-cycle pulse, sixteen per bit period |
| rx_en | input | 1 | Receive enable |
| mp_en | input | 1 | Multiprocessor mode: accept only ninth bit = 1 |
| flag_clr | input | 1 | One-cycle strobe that clears rx_full |
| rx_data | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_full | output | 1 | Receive-complete flag |

## Verification
The properties assume that flag_clr and mp_en are plain synchronous levels that change only between clock edges. They also assume that tick16 is a single-cycle pulse no more often than every other clock. The bench drives every input on the falling clock edge, issues tick16 every fourth cycle, and holds each serial bit for exactly sixteen ticks. It re-enables reception only while the line idles high, so glitches are deliberate short low pulses and not artefacts of enable changes.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_SHIFT = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;

endpackage

// File: rtl/uart9_sync.sv
module uart9_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/uart9_framer.sv
module uart9_framer
  import uart9_pkg::*;
#(
  parameter int OSR     = 16,
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               rx_s,
  input  logic               rx_en,
  output logic               done,
  output logic [FRAME_W-1:0] frame
);

  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(FRAME_W);
  localparam logic [CW-1:0] CNT_HALF = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_W - 1);

  rx_state_t          st_q,   st_d;
  logic [CW-1:0]      cnt_q,  cnt_d;
  logic [IW-1:0]      idx_q,  idx_d;
  logic [FRAME_W-1:0] sh_q,   sh_d;
  logic               prev_q, prev_d;
  logic               upd_en;

  assign upd_en = tick | ~rx_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    prev_d = prev_q;
    done   = 1'b0;
    if (tick) prev_d = rx_s;
    if (!rx_en) begin
      st_d = ST_IDLE;
    end else if (tick) begin
      case (st_q)
        ST_IDLE: begin
          if (prev_q && !rx_s) begin
            st_d  = ST_START;
            cnt_d = '0;
          end
        end
        ST_START: begin
          if (cnt_q == CNT_HALF) begin
            if (!rx_s) begin
              st_d  = ST_SHIFT;
              cnt_d = '0;
              idx_d = '0;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (cnt_q == CNT_LAST) begin
            sh_d  = {rx_s, sh_q[FRAME_W-1:1]};
            cnt_d = '0;
            if (idx_q == IDX_LAST) st_d = ST_STOP;
            else                   idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == CNT_LAST) begin
            done = 1'b1;
            st_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      prev_q <= 1'b1;
    end else if (upd_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign frame = sh_q;

endmodule

// File: rtl/uart9_accept.sv
module uart9_accept #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W:0]   frame,
  input  logic              mp_en,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] data,
  output logic              bit9,
  output logic              full
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;
  logic              bit9_q;
  logic              take;

  always_comb begin
    take   = done & ~full_q & (~mp_en | frame[DATA_W]);
    full_d = take | (full_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      bit9_q <= 1'b0;
    end else if (take) begin
      data_q <= frame[DATA_W-1:0];
      bit9_q <= frame[DATA_W];
    end
  end

  assign data = data_q;
  assign bit9 = bit9_q;
  assign full = full_q;

endmodule

// File: rtl/uart9_addr_rx.sv
module uart9_addr_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              tick16,
  input  logic              rx_en,
  input  logic              mp_en,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_full
);

  localparam int FRAME_W = DATA_W + 1;

  logic               rst_int_n;
  logic               rx_s;
  logic               done;
  logic [FRAME_W-1:0] frame;

  uart9_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  uart9_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (rx_in),
    .q     (rx_s)
  );

  uart9_framer #(.OSR(OSR), .FRAME_W(FRAME_W)) u_framer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick16),
    .rx_s  (rx_s),
    .rx_en (rx_en),
    .done  (done),
    .frame (frame)
  );

  uart9_accept #(.DATA_W(DATA_W)) u_accept (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .done     (done),
    .frame    (frame),
    .mp_en    (mp_en),
    .flag_clr (flag_clr),
    .data     (rx_data),
    .bit9     (rx_bit9),
    .full     (rx_full)
  );

endmodule

// File: rtl/uart9_addr_rx_chk.sv
module uart9_addr_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              mp_en,
  input logic              flag_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              rx_full
);

  a_r1_disabled_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_full) |=> !rx_full);

  a_r2_load_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_full |=> (rx_full || ($stable(rx_data) && $stable(rx_bit9))));

  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> ($stable(rx_data) && $stable(rx_bit9)));

  a_r4_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_en && !rx_full) |=> (!rx_full || rx_bit9));

  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !flag_clr) |=> rx_full);

  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && flag_clr) |=> !rx_full);

endmodule

bind uart9_addr_rx uart9_addr_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_en    (rx_en),
  .mp_en    (mp_en),
  .flag_clr (flag_clr),
  .rx_data  (rx_data),
  .rx_bit9  (rx_bit9),
  .rx_full  (rx_full)
);

// File: tb/sim_uart9_addr_rx.sv
`timescale 1ns/1ps
module sim_uart9_addr_rx;

  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst_n, rx_in, tick16, rx_en, mp_en, flag_clr;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_full;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmp_en = 0;

  always #2 clk = ~clk;

  uart9_addr_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16),
    .rx_en(rx_en), .mp_en(mp_en), .flag_clr(flag_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full)
  );

  // behavioural reference
  bit       m_s1, m_s2, m_prev, m_done, m_take;
  int       m_phase, m_cnt, m_idx;
  bit [8:0] m_sh;
  bit [7:0] m_data;
  bit       m_b9, m_full;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_phase = 0; m_cnt = 0; m_idx = 0;
      m_sh = 0; m_data = 0; m_b9 = 0; m_full = 0;
    end else begin
      m_done = 0;
      if (!rx_en) m_phase = 0;
      else if (tick16) begin
        if (m_phase == 0) begin
          if (m_prev && !m_s2) begin m_phase = 1; m_cnt = 0; end
        end else if (m_phase == 1) begin
          if (m_cnt == 7) begin
            if (!m_s2) begin m_phase = 2; m_cnt = 0; m_idx = 0; end
            else m_phase = 0;
          end else m_cnt++;
        end else if (m_phase == 2) begin
          if (m_cnt == 15) begin
            m_sh = {m_s2, m_sh[8:1]};
            m_cnt = 0;
            if (m_idx == 8) m_phase = 3; else m_idx++;
          end else m_cnt++;
        end else begin
          if (m_cnt == 15) begin m_done = 1; m_phase = 0; end
          else m_cnt++;
        end
      end
      if (tick16) m_prev = m_s2;
      m_take = m_done && !m_full && (!mp_en || m_sh[8]);
      if (flag_clr) m_full = 0;
      if (m_take) begin m_full = 1; m_data = m_sh[7:0]; m_b9 = m_sh[8]; end
      m_s2 = m_s1;
      m_s1 = rx_in;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      checks++;
      if (rx_data !== m_data || rx_bit9 !== m_b9 || rx_full !== m_full) begin
        errors++;
        $display("FAIL R7 cycle compare: actual %h/%b/%b expected %h/%b/%b",
                 rx_data, rx_bit9, rx_full, m_data, m_b9, m_full);
      end
    end
  end

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rx_in = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stp);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(b9);
    drive_bit(stp);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int div;
    tick16 = 1'b0;
    div = 0;
    forever begin
      @(negedge clk);
      div++;
      tick16 = (div % 4 == 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_in = 1'b1; rx_en = 1'b0; mp_en = 1'b0; flag_clr = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 reset full", {8'h0, rx_full}, 9'h0);
    chk("R9 reset bit9", {8'h0, rx_bit9}, 9'h0);
    chk("R9 reset data", {1'b0, rx_data}, 9'h0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    cmp_en = 1;
    rx_en = 1'b1;
    repeat (8) @(negedge clk);

    // R5 / R2: plain mode, data frame
    send(8'hA5, 1'b0, 1'b1);
    chk("R5 accept ninth=0", {8'h0, rx_full}, 9'h1);
    chk("R2 data lsb first", {rx_bit9, rx_data}, {1'b0, 8'hA5});

    // R3: second frame while full
    send(8'h5A, 1'b1, 1'b1);
    chk("R3 no overwrite", {rx_bit9, rx_data}, {1'b0, 8'hA5});
    chk("R3 flag still set", {8'h0, rx_full}, 9'h1);

    // R8: clear
    pulse_clr();
    chk("R8 flag cleared", {8'h0, rx_full}, 9'h0);

    // R2: stop bit low still accepted; R5 with ninth=1
    send(8'h3C, 1'b1, 1'b0);
    chk("R2 stop ignored", {8'h0, rx_full}, 9'h1);
    chk("R5 accept ninth=1", {rx_bit9, rx_data}, {1'b1, 8'h3C});
    pulse_clr();

    // R4: multiprocessor mode
    mp_en = 1'b1;
    send(8'h55, 1'b0, 1'b1);
    chk("R4 data frame dropped", {8'h0, rx_full}, 9'h0);
    chk("R4 regs kept", {rx_bit9, rx_data}, {1'b1, 8'h3C});
    send(8'h81, 1'b1, 1'b1);
    chk("R4 address accepted", {rx_full, rx_data}, {1'b1, 8'h81});
    mp_en = 1'b0;
    pulse_clr();

    // R6: glitch then a real frame
    rx_in = 1'b0;
    repeat (8) @(negedge clk);
    rx_in = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk("R6 glitch no load", {8'h0, rx_full}, 9'h0);
    send(8'h12, 1'b0, 1'b1);
    chk("R6 frame after glitch", {rx_full, rx_data}, {1'b1, 8'h12});
    pulse_clr();

    // R1: disabled, then abort mid-frame
    rx_en = 1'b0;
    send(8'h77, 1'b0, 1'b1);
    chk("R1 disabled no load", {rx_full, rx_data}, {1'b0, 8'h12});
    rx_en = 1'b1;
    drive_bit(1'b0);
    for (int i = 0; i < 4; i++) drive_bit(i[0]);
    rx_en = 1'b0;
    for (int i = 0; i < 5; i++) drive_bit(~i[0]);
    drive_bit(1'b1);
    drive_bit(1'b1);
    chk("R1 abort no load", {rx_full, rx_data}, {1'b0, 8'h12});
    rx_en = 1'b1;
    drive_bit(1'b1);
    send(8'h0F, 1'b0, 1'b1);
    chk("R1 re-enable works", {rx_full, rx_data}, {1'b1, 8'h0F});

    // R8: flag held without strobe
    repeat (200) @(negedge clk);
    chk("R8 flag held", {8'h0, rx_full}, 9'h1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule